// File: doc/BRIEF.md
# Parity-Checked Line Receiver

This block collects one text line from a terminal-style byte stream. Each incoming byte carries even parity in bit 7. The block checks the parity and drops bytes that fail it, setting a sticky flag. Bytes that pass have bit 7 cleared and are written in order into an on-chip line buffer. A carriage return ends the line. The block then writes a line feed after it, reports completion and stops accepting input.

If the line grows to its limit without a carriage return, the block reports overflow. It then turns off the receive side and turns on the transmit side, so the host can send an error message byte by byte through the data-out register. The host reaches everything through a small register port at fixed byte addresses. It reads the finished line through a separate buffer read port. A level interrupt tells the host when an enabled condition is pending.

Top module: `lr_top`

## Requirements
- R1: After reset, status (0x54) reads 0x01 (transmit empty only), the count (0x55) is 0, and `irq`, `rx_ready` and `tx_valid` are low.
- R2: A byte with even parity over all 8 bits is accepted and stored at the next free buffer index as `{1'b0, byte[6:0]}`, and the count goes up by one.
- R3: A byte with odd parity is consumed but not stored. The count does not change, and status bit 2 (parity error) becomes 1 and stays 1 until a clear.
- R4: A stored 0x0D is followed in the very next cycle by 0x0A in the next buffer slot. The result code (status bits 4:3) then becomes 2, input enable (status bit 6) becomes 0, and `rx_ready` goes low.
- R5: When the 81st stored character is not 0x0D, the result code becomes 1, input enable becomes 0, output enable (status bit 5) becomes 1, and the count is 81.
- R6: A 0x0D that arrives as the 81st character completes the line (code 2, count 82) and does not cause an overflow.
- R7: Reading 0x52 returns the last stored character and clears receive-ready (status bit 1). Status bit 0 means the transmit register is empty.
- R8: Writing 0x53 loads `tx_data` and raises `tx_valid`, which stays high with stable data until `tx_ready` is seen high. After that, transmit-empty returns to 1.
- R9: `irq` is high exactly when (input enabled and receive-ready) or (output enabled and transmit-empty).
- R10: A write to 0x54 sets output enable from bit 0 and input enable from bit 1. Bit 7 set, or a 0-to-1 change of input enable, resets the count, the code and the parity flag to 0.
- R11: While input is disabled or the code is not 0, `rx_ready` is low and bytes offered on the receive port leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Received byte, bit 7 is parity |
| rx_ready | output | 1 | Block accepts a byte this cycle |
| tx_valid | output | 1 | Data-out byte pending |
| tx_data | output | 8 | Data-out byte |
| tx_ready | input | 1 | Sink takes the pending byte |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe |
| hst_addr | input | 8 | Host register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data (combinational) |
| buf_raddr | input | 7 | Line buffer read index |
| buf_rdata | output | 8 | Line buffer contents at that index |
| irq | output | 1 | Interrupt request, level |

## Verification
Two situations are hard to reach from the ports: the 81st character being a carriage return, and the 81st being an ordinary character. Both need exactly 81 good-parity bytes with no early terminator. The stimulus therefore generates lines of letters of chosen lengths, encodes parity arithmetically, and ends them with either a carriage return or nothing. A sweep over all 256 byte values, with a clear before each one, covers the parity split and bit-7 stripping for every character except the terminator.

// File: rtl/lr_pkg.sv
package lr_pkg;
    typedef enum logic [1:0] {
        CODE_IDLE = 2'd0,
        CODE_OVF  = 2'd1,
        CODE_DONE = 2'd2
    } code_e;

    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;
endpackage

// File: rtl/lr_rx_check.sv
module lr_rx_check (
    input  logic [7:0] byte_i,
    output logic       par_ok_o,
    output logic [7:0] char_o,
    output logic       is_cr_o
);
    always_comb begin
        par_ok_o = ~(^byte_i);
        char_o   = {1'b0, byte_i[6:0]};
        is_cr_o  = (char_o == lr_pkg::CH_CR);
    end
endmodule

// File: rtl/lr_linebuf.sv
module lr_linebuf #(
    parameter int DEPTH = 82,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        if (int'(raddr) < DEPTH) rdata = mem_q[raddr];
        else                     rdata = 8'h00;
    end
endmodule

// File: rtl/lr_hostdec.sv
module lr_hostdec #(
    parameter logic [7:0] PORT_DIN  = 8'h52,
    parameter logic [7:0] PORT_DOUT = 8'h53,
    parameter logic [7:0] PORT_CSR  = 8'h54,
    parameter logic [7:0] PORT_CNT  = 8'h55
) (
    input  logic [7:0] addr,
    input  logic       wr,
    input  logic       rd,
    output logic [3:0] sel,
    output logic       rd_din,
    output logic       wr_dout,
    output logic       wr_csr
);
    localparam logic [7:0] MAP [4] = '{PORT_DIN, PORT_DOUT, PORT_CSR, PORT_CNT};

    for (genvar g = 0; g < 4; g++) begin : g_sel
        assign sel[g] = (addr == MAP[g]);
    end

    always_comb begin
        rd_din  = rd && sel[0];
        wr_dout = wr && sel[1];
        wr_csr  = wr && sel[2];
    end
endmodule

// File: rtl/lr_top.sv
module lr_top #(
    parameter int         LINE_MAX  = 80,
    parameter logic [7:0] PORT_DIN  = 8'h52,
    parameter logic [7:0] PORT_DOUT = 8'h53,
    parameter logic [7:0] PORT_CSR  = 8'h54,
    parameter logic [7:0] PORT_CNT  = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    input  logic       hst_wr,
    input  logic       hst_rd,
    input  logic [7:0] hst_addr,
    input  logic [7:0] hst_wdata,
    output logic [7:0] hst_rdata,
    input  logic [6:0] buf_raddr,
    output logic [7:0] buf_rdata,
    output logic       irq
);
    import lr_pkg::*;

    localparam int DEPTH = LINE_MAX + 2;
    localparam int LIMIT = LINE_MAX + 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int AW    = 7;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic             in_en;
        logic             out_en;
        logic             rx_rdy;
        logic             tx_empty;
        logic             perr;
        logic             lf_pend;
        code_e            code;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       din;
        logic [7:0]       dout;
    } st_t;

    st_t st_q, st_d;

    logic       par_ok, is_cr;
    logic [7:0] chr;
    logic [3:0] sel;
    logic       rd_din, wr_dout, wr_csr;
    logic       we;
    logic [AW-1:0] waddr;
    logic [7:0] wdata;
    logic       rx_take;

    lr_rx_check u_chk_rx (
        .byte_i   (rx_data),
        .par_ok_o (par_ok),
        .char_o   (chr),
        .is_cr_o  (is_cr)
    );

    lr_hostdec #(
        .PORT_DIN (PORT_DIN),
        .PORT_DOUT(PORT_DOUT),
        .PORT_CSR (PORT_CSR),
        .PORT_CNT (PORT_CNT)
    ) u_dec (
        .addr   (hst_addr),
        .wr     (hst_wr),
        .rd     (hst_rd),
        .sel    (sel),
        .rd_din (rd_din),
        .wr_dout(wr_dout),
        .wr_csr (wr_csr)
    );

    lr_linebuf #(
        .DEPTH(DEPTH),
        .AW   (AW)
    ) u_buf (
        .clk  (clk),
        .we   (we),
        .waddr(waddr),
        .wdata(wdata),
        .raddr(buf_raddr),
        .rdata(buf_rdata)
    );

    always_comb begin
        rx_ready = st_q.in_en && (st_q.code == CODE_IDLE) && !st_q.lf_pend;
        rx_take  = rx_valid && rx_ready;
        tx_valid = !st_q.tx_empty;
        tx_data  = st_q.dout;
        irq      = (st_q.in_en && st_q.rx_rdy) || (st_q.out_en && st_q.tx_empty);
    end

    always_comb begin
        st_d  = st_q;
        we    = 1'b0;
        waddr = AW'(st_q.cnt);
        wdata = chr;

        // line assembly
        if (st_q.lf_pend) begin
            we           = 1'b1;
            wdata        = CH_LF;
            st_d.cnt     = st_q.cnt + 1'b1;
            st_d.lf_pend = 1'b0;
            st_d.code    = CODE_DONE;
            st_d.in_en   = 1'b0;
        end else if (rx_take) begin
            if (!par_ok) begin
                st_d.perr = 1'b1;
            end else begin
                we          = 1'b1;
                st_d.cnt    = st_q.cnt + 1'b1;
                st_d.din    = chr;
                st_d.rx_rdy = 1'b1;
                if (is_cr) begin
                    st_d.lf_pend = 1'b1;
                end else if (st_q.cnt == LAST_IDX) begin
                    st_d.code   = CODE_OVF;
                    st_d.in_en  = 1'b0;
                    st_d.out_en = 1'b1;
                end
            end
        end

        // transmit side
        if (tx_valid && tx_ready) st_d.tx_empty = 1'b1;

        // host accesses take effect after line logic
        if (rd_din) st_d.rx_rdy = 1'b0;
        if (wr_dout) begin
            st_d.dout     = hst_wdata;
            st_d.tx_empty = 1'b0;
        end
        if (wr_csr) begin
            st_d.out_en = hst_wdata[0];
            st_d.in_en  = hst_wdata[1];
            if (hst_wdata[7] || (hst_wdata[1] && !st_q.in_en)) begin
                st_d.code    = CODE_IDLE;
                st_d.cnt     = '0;
                st_d.perr    = 1'b0;
                st_d.lf_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.code     <= CODE_IDLE;
            st_q.tx_empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        hst_rdata = 8'h00;
        case (1'b1)
            sel[0]: hst_rdata = st_q.din;
            sel[1]: hst_rdata = st_q.dout;
            sel[2]: hst_rdata = {1'b0, st_q.in_en, st_q.out_en, st_q.code,
                                 st_q.perr, st_q.rx_rdy, st_q.tx_empty};
            sel[3]: hst_rdata = 8'(st_q.cnt);
            default: hst_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/lr_chk.sv
module lr_chk #(
    parameter int         CNT_W     = 7,
    parameter int         DEPTH     = 82,
    parameter logic [7:0] PORT_DOUT = 8'h53,
    parameter logic [7:0] PORT_CSR  = 8'h54
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic [7:0]       rx_data,
    input logic             rx_ready,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             hst_wr,
    input logic [7:0]       hst_addr,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [1:0]       code,
    input logic             lf_pend,
    input logic             in_en,
    input logic             out_en
);
    localparam logic [CNT_W-1:0] CMAX  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] PRE_L = CNT_W'(DEPTH - 2);

    logic csr_wr, dout_wr, take;
    assign csr_wr  = hst_wr && (hst_addr == PORT_CSR);
    assign dout_wr = hst_wr && (hst_addr == PORT_DOUT);
    assign take    = rx_valid && rx_ready && !lf_pend;

    a_r2_good_byte_counts: assert property (@(posedge clk) disable iff (!rst_n)
        take && !(^rx_data) && !csr_wr |=> cnt == $past(cnt) + 1'b1);

    a_r3_odd_byte_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        take && (^rx_data) && !csr_wr |=> cnt == $past(cnt));

    a_r4_lf_closes_line: assert property (@(posedge clk) disable iff (!rst_n)
        lf_pend && !csr_wr |=> code == 2'd2 && !rx_ready && !in_en);

    a_r5_overflow_switch: assert property (@(posedge clk) disable iff (!rst_n)
        take && !(^rx_data) && rx_data[6:0] != 7'h0D && cnt == PRE_L && !csr_wr
        |=> code == 2'd1 && out_en && !in_en);

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CMAX);

    a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !dout_wr |=> tx_valid && $stable(tx_data));

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> in_en || out_en);
endmodule

bind lr_top lr_chk #(
    .CNT_W    (CNT_W),
    .DEPTH    (DEPTH),
    .PORT_DOUT(PORT_DOUT),
    .PORT_CSR (PORT_CSR)
) u_lr_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_valid(rx_valid),
    .rx_data (rx_data),
    .rx_ready(rx_ready),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_data (tx_data),
    .hst_wr  (hst_wr),
    .hst_addr(hst_addr),
    .irq     (irq),
    .cnt     (st_q.cnt),
    .code    (st_q.code),
    .lf_pend (st_q.lf_pend),
    .in_en   (st_q.in_en),
    .out_en  (st_q.out_en)
);

// File: tb/sim_lr_top.sv
module sim_lr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ready;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       hst_wr = 1'b0, hst_rd = 1'b0;
    logic [7:0] hst_addr = 8'h00, hst_wdata = 8'h00, hst_rdata;
    logic [6:0] buf_raddr = 7'd0;
    logic [7:0] buf_rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lr_top u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .buf_raddr(buf_raddr), .buf_rdata(buf_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic hrd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        hst_rd = 1'b1; hst_addr = a;
        #1 d = hst_rdata;
        @(negedge clk);
        hst_rd = 1'b0;
    endtask

    task automatic brd(input int idx, output logic [7:0] d);
        buf_raddr = 7'(idx);
        #1 d = buf_rdata;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    function automatic logic [7:0] enc(input logic [6:0] c);
        return {^c, c};
    endfunction

    function automatic logic [6:0] letter(input int i);
        return 7'(8'h41 + (i % 26));
    endfunction

    task automatic line_case(input int len, input bit with_cr, input string tag);
        logic [7:0] d;
        hwr(8'h54, 8'h82);
        for (int i = 0; i < len; i++) send(enc(letter(i)));
        if (with_cr) send(enc(7'h0D));
        @(negedge clk);
        hrd(8'h55, d);
        if (with_cr) chk({tag, " count"}, d, len + 2);
        else         chk({tag, " count"}, d, len);
        for (int i = 0; i < len; i++) begin
            brd(i, d);
            chk({tag, " R2 char"}, d, {1'b0, letter(i)});
        end
        hrd(8'h54, d);
        if (with_cr) begin
            chk({tag, " code"}, (d >> 3) & 3, 2);
            chk({tag, " in_en"}, d[6], 0);
            chk({tag, " rx_ready"}, rx_ready, 0);
            brd(len, d);     chk({tag, " R4 CR"}, d, 8'h0D);
            brd(len + 1, d); chk({tag, " R4 LF"}, d, 8'h0A);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hrd(8'h54, d); chk("R1 status", d, 8'h01);
        hrd(8'h55, d); chk("R1 count", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rx_ready", rx_ready, 0);
        chk("R1 tx_valid", tx_valid, 0);

        // R11 disabled input ignores bytes
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h41;
        repeat (4) @(negedge clk);
        chk("R11 rx_ready while disabled", rx_ready, 0);
        rx_valid = 1'b0;
        hrd(8'h55, d); chk("R11 count unchanged", d, 0);

        // R2 R3 sweep over all byte values
        for (int b = 0; b < 256; b++) begin
            logic [7:0] bb;
            bit good;
            bb = 8'(b);
            if (bb[6:0] == 7'h0D) continue;
            good = ~(^bb);
            hwr(8'h54, 8'h82);
            send(bb);
            hrd(8'h55, d);
            chk(good ? "R2 count" : "R3 count", d, good ? 1 : 0);
            hrd(8'h54, d);
            chk("R3 perr flag", d[2], good ? 0 : 1);
            if (good) begin
                brd(0, d);
                chk("R2 stripped", d, {1'b0, bb[6:0]});
            end
        end

        // R10 clear zeroes perr and count
        hwr(8'h54, 8'h82);
        send(8'h01);
        hwr(8'h54, 8'h82);
        hrd(8'h54, d); chk("R10 perr cleared", d[2], 0);

        // R4 lines of several lengths, R6 at the limit
        line_case(0, 1, "R4 len0");
        line_case(1, 1, "R4 len1");
        line_case(5, 1, "R4 len5");
        line_case(79, 1, "R4 len79");
        line_case(80, 1, "R6 len80");

        // R10 re-enable after completion
        hwr(8'h54, 8'h02);
        hrd(8'h55, d); chk("R10 count after reenable", d, 0);
        hrd(8'h54, d); chk("R10 code after reenable", (d >> 3) & 3, 0);
        chk("R10 rx_ready", rx_ready, 1);

        // R7 R9 receive interrupt
        hrd(8'h52, d);
        chk("R9 irq idle", irq, 0);
        send(enc(7'h5A));
        chk("R9 irq rx", irq, 1);
        hrd(8'h52, d); chk("R7 data-in", d, 8'h5A);
        chk("R9 irq cleared by read", irq, 0);
        hrd(8'h54, d); chk("R7 rx ready bit", d[1], 0);

        // R5 overflow
        line_case(81, 0, "R5 ovf");
        hrd(8'h54, d); chk("R5 status", d, 8'h2B);
        chk("R5 rx_ready", rx_ready, 0);
        chk("R9 irq tx empty", irq, 1);

        // R8 transmit handshake
        hwr(8'h53, 8'h45);
        chk("R8 tx_valid", tx_valid, 1);
        chk("R8 tx_data", tx_data, 8'h45);
        chk("R9 irq after load", irq, 0);
        hrd(8'h54, d); chk("R7 tx empty bit", d[0], 0);
        repeat (3) @(negedge clk);
        chk("R8 hold valid", tx_valid, 1);
        chk("R8 hold data", tx_data, 8'h45);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R8 drained", tx_valid, 0);
        chk("R9 irq after drain", irq, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule